// File: doc/BRIEF.md
# Paired Interrupt Aggregator With Vector

This block gathers the interrupt status of four two-channel serial blocks onto two shared interrupt lines. Each block keeps an 8-bit status byte whose bits are set and cleared by strobes from the channel datapath, and an 8-bit mask written by the host. The first pair of blocks drives line 0 and the second pair drives line 1. A line is raised when any status bit in its two blocks is also enabled in the same block's mask.

The block also decodes the host byte address into a block index, a channel index and a register offset. It serves the status read, the mask write and the break-clear command. It holds a host-programmed vector byte, which is returned when the host reads the acknowledge space. Counter/timer and input-port change sources are not present, so their status bits are tied low.

Top module: `intr_pair_agg`

## Requirements
- R1: After reset every status byte, every mask byte and the vector are zero, and both interrupt lines are low.
- R2: A set strobe sets its status bit and a clear strobe clears it, both at the next clock. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R3: Status bits 3 (counter ready) and 7 (input-port change) of every block always read zero, even when their set strobes are driven.
- R4: In the I/O space (`bus_space`=0), the status/mask location of a block is the byte address whose low five bits are 0x0A, which is register offset 0x0B. A read there returns that block's status byte. A write there loads the block's mask and leaves its status unchanged.
- R5: Line 0 is high when (status AND mask) is nonzero in block 0 or block 1. Line 1 is high under the same condition for block 2 or block 3. Each line follows the stored status and mask one clock later.
- R6: For an I/O access the block index is address bits [7:5], the channel index is bits [7:4], and the register offset is bits [4:0] with bit 0 inverted. Block indices 4 to 7 have no storage: reads there return zero and writes change nothing.
- R7: An I/O write to register offset 0x05 or 0x15 whose data bits [7:4] equal 5 clears status bits 2 and 6 (the two break bits) of the addressed block. A set strobe in the same cycle still wins. Any other command code leaves the status unchanged.
- R8: A write at address 1 in the ID space (`bus_space`=1) or in the memory space (`bus_space`=3) loads the vector byte. Writes at any other address in those spaces, and all writes in the acknowledge space, leave it unchanged.
- R9: A read in the acknowledge space (`bus_space`=2) at address 0 (line 0) or address 2 (line 1) returns the vector byte. A read at any other address there returns zero, and `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_space | input | 2 | Access space: 0 I/O, 1 ID, 2 acknowledge, 3 memory |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Host byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from stored state |
| dec_blk | output | 3 | Decoded block index |
| dec_chan | output | 4 | Decoded channel index |
| dec_reg | output | 5 | Decoded register offset |
| sts_set | input | 32 | Per-block status set strobes, block b at bits [8b+7:8b] |
| sts_clr | input | 32 | Per-block status clear strobes, same layout |
| irq_line | output | 2 | Interrupt lines, bit 0 for blocks 0/1, bit 1 for blocks 2/3 |

## Verification
Several behaviours are checked by assertions on every cycle: the one-cycle tracking of each line against the masked status of its block pair, set-over-clear priority, the tied-low bits, mask and vector stability when no qualifying write occurs, and the acknowledge data. The bench scenarios cover what these properties cannot express: the full address decode, including the unpopulated upper blocks, the break-clear command against the other command codes, and the vector write paths in each space. They also cover the exact values returned by status reads, the mask write leaving status intact, and the reset state.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

   typedef enum logic [1:0] {
      SP_IO  = 2'd0,
      SP_ID  = 2'd1,
      SP_ACK = 2'd2,
      SP_MEM = 2'd3
   } bus_space_e;

   // register offsets after the bit-0 swap
   localparam logic [4:0] OFS_STAT_MASK = 5'h0B;
   localparam logic [4:0] OFS_CMD_EVEN  = 5'h05;
   localparam logic [4:0] OFS_CMD_ODD   = 5'h15;

   // command nibble that drops both break flags of a block
   localparam logic [3:0] CMD_BRK_CLEAR = 4'h5;

   // status bit roles
   localparam int unsigned BIT_BRK_EVEN = 2;
   localparam int unsigned BIT_BRK_ODD  = 6;
   localparam int unsigned BIT_CNT_RDY  = 3;
   localparam int unsigned BIT_IN_CHG   = 7;

   localparam logic [7:0] BRK_BITS = 8'h44;
   localparam logic [7:0] TIE_BITS = 8'h88;

endpackage

// File: rtl/intr_addr_dec.sv
module intr_addr_dec #(
   parameter int unsigned AW       = 8,
   parameter int unsigned OFS_BITS = 5,
   parameter int unsigned NBLK     = 4,
   localparam int unsigned BLK_BITS = AW - OFS_BITS,
   localparam int unsigned CH_BITS  = BLK_BITS + 1
) (
   input  logic [AW-1:0]       addr,
   output logic [BLK_BITS-1:0] blk_idx,
   output logic [CH_BITS-1:0]  ch_idx,
   output logic [OFS_BITS-1:0] reg_ofs,
   output logic [NBLK-1:0]     blk_hit
);

   generate
      if (AW <= OFS_BITS) begin : g_bad_aw
         $error("address must be wider than the register offset");
      end
   endgenerate

   assign blk_idx = addr[AW-1 -: BLK_BITS];
   assign ch_idx  = addr[AW-1 -: CH_BITS];
   assign reg_ofs = addr[OFS_BITS-1:0] ^ OFS_BITS'(1);

   for (genvar b = 0; b < NBLK; b++) begin : g_hit
      assign blk_hit[b] = (blk_idx == BLK_BITS'(b));
   end

endmodule

// File: rtl/intr_stat_blk.sv
module intr_stat_blk #(
   parameter int unsigned DW       = 8,
   parameter logic [DW-1:0] TIE    = '0,
   parameter logic [DW-1:0] BRK    = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_i,
   input  logic [DW-1:0] clr_i,
   input  logic          brk_clr_i,
   input  logic          mask_we_i,
   input  logic [DW-1:0] mask_d_i,
   output logic [DW-1:0] sts_o,
   output logic [DW-1:0] msk_o
);

   logic [DW-1:0] sts_q, msk_q;
   logic [DW-1:0] drop, sts_d;

   always_comb begin
      drop = clr_i;
      if (brk_clr_i) begin
         drop = drop | BRK;
      end
      // set has priority over every clear source
      sts_d = ((sts_q & ~drop) | set_i) & ~TIE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         msk_q <= '0;
      end else begin
         sts_q <= sts_d;
         if (mask_we_i) begin
            msk_q <= mask_d_i;
         end
      end
   end

   assign sts_o = sts_q;
   assign msk_o = msk_q;

endmodule

// File: rtl/intr_line_eval.sv
module intr_line_eval #(
   parameter int unsigned DW   = 8,
   parameter int unsigned NBLK = 4,
   parameter int unsigned GRP  = 2,
   localparam int unsigned NLINE = NBLK / GRP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NBLK*DW-1:0] sts_flat,
   input  logic [NBLK*DW-1:0] msk_flat,
   output logic [NLINE-1:0]   irq_o
);

   logic [NLINE-1:0] hit_vec;
   logic [NLINE-1:0] irq_q;

   for (genvar k = 0; k < NLINE; k++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int j = 0; j < GRP; j++) begin
            hit = hit | (|(sts_flat[(k*GRP+j)*DW +: DW] &
                           msk_flat[(k*GRP+j)*DW +: DW]));
         end
      end
      assign hit_vec[k] = hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= '0;
      end else begin
         irq_q <= hit_vec;
      end
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/intr_vec_reg.sv
module intr_vec_reg #(
   parameter int unsigned   DW       = 8,
   parameter int unsigned   AW       = 8,
   parameter int unsigned   VEC_ADDR = 1,
   parameter logic [DW-1:0] VEC_RST  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_id_i,
   input  logic          wr_mem_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] vec_o
);

   logic [DW-1:0] vec_q;
   logic          load;

   assign load = (wr_id_i || wr_mem_i) && (addr_i == AW'(VEC_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q <= VEC_RST;
      end else if (load) begin
         vec_q <= wdata_i;
      end
   end

   assign vec_o = vec_q;

endmodule

// File: rtl/intr_pair_agg.sv
module intr_pair_agg
   import intr_agg_pkg::*;
#(
   parameter int unsigned AW           = 8,
   parameter int unsigned DW           = 8,
   parameter int unsigned NBLK         = 4,
   parameter int unsigned BLK_PER_LINE = 2,
   parameter int unsigned OFS_BITS     = 5,
   parameter logic [7:0]  VEC_RST      = 8'h00,
   localparam int unsigned NLINE    = NBLK / BLK_PER_LINE,
   localparam int unsigned BLK_BITS = AW - OFS_BITS,
   localparam int unsigned CH_BITS  = BLK_BITS + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          bus_space,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [AW-1:0]       bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   output logic [BLK_BITS-1:0] dec_blk,
   output logic [CH_BITS-1:0]  dec_chan,
   output logic [OFS_BITS-1:0] dec_reg,
   input  logic [NBLK*DW-1:0]  sts_set,
   input  logic [NBLK*DW-1:0]  sts_clr,
   output logic [NLINE-1:0]    irq_line
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("status byte layout needs DW of 8");
      end
      if (OFS_BITS != 5) begin : g_bad_ofs
         $error("register offsets assume a 5-bit field");
      end
      if ((NBLK % BLK_PER_LINE) != 0) begin : g_bad_grp
         $error("blocks must divide evenly among lines");
      end
      if (NBLK > (1 << BLK_BITS)) begin : g_bad_nblk
         $error("more blocks than the address can select");
      end
   endgenerate

   logic [NBLK-1:0]    blk_hit;
   logic [NBLK*DW-1:0] sts_flat, msk_flat;
   logic [DW-1:0]      vec_q;
   logic               io_wr, io_rd, ack_rd;
   logic               sel_stat, sel_cmd, cmd_brk;

   intr_addr_dec #(
      .AW       (AW),
      .OFS_BITS (OFS_BITS),
      .NBLK     (NBLK)
   ) i_dec (
      .addr    (bus_addr),
      .blk_idx (dec_blk),
      .ch_idx  (dec_chan),
      .reg_ofs (dec_reg),
      .blk_hit (blk_hit)
   );

   assign io_wr  = bus_wr && (bus_space == SP_IO);
   assign io_rd  = bus_rd && (bus_space == SP_IO);
   assign ack_rd = bus_rd && (bus_space == SP_ACK);

   assign sel_stat = (dec_reg == OFS_STAT_MASK);
   assign sel_cmd  = (dec_reg == OFS_CMD_EVEN) || (dec_reg == OFS_CMD_ODD);
   assign cmd_brk  = sel_cmd && (bus_wdata[DW-1 -: 4] == CMD_BRK_CLEAR);

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      intr_stat_blk #(
         .DW  (DW),
         .TIE (TIE_BITS),
         .BRK (BRK_BITS)
      ) i_stat (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (sts_set[b*DW +: DW]),
         .clr_i     (sts_clr[b*DW +: DW]),
         .brk_clr_i (io_wr && blk_hit[b] && cmd_brk),
         .mask_we_i (io_wr && blk_hit[b] && sel_stat),
         .mask_d_i  (bus_wdata),
         .sts_o     (sts_flat[b*DW +: DW]),
         .msk_o     (msk_flat[b*DW +: DW])
      );
   end

   intr_line_eval #(
      .DW   (DW),
      .NBLK (NBLK),
      .GRP  (BLK_PER_LINE)
   ) i_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .sts_flat (sts_flat),
      .msk_flat (msk_flat),
      .irq_o    (irq_line)
   );

   intr_vec_reg #(
      .DW       (DW),
      .AW       (AW),
      .VEC_ADDR (1),
      .VEC_RST  (VEC_RST)
   ) i_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_id_i  (bus_wr && (bus_space == SP_ID)),
      .wr_mem_i (bus_wr && (bus_space == SP_MEM)),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .vec_o    (vec_q)
   );

   // read path: status in I/O space, vector in acknowledge space
   always_comb begin
      bus_rdata = '0;
      if (io_rd && sel_stat) begin
         for (int b = 0; b < NBLK; b++) begin
            if (blk_hit[b]) begin
               bus_rdata = sts_flat[b*DW +: DW];
            end
         end
      end else if (ack_rd) begin
         for (int k = 0; k < NLINE; k++) begin
            if (bus_addr == AW'(2*k)) begin
               bus_rdata = vec_q;
            end
         end
      end
   end

endmodule

// File: rtl/intr_pair_agg_chk.sv
module intr_pair_agg_chk #(
   parameter int unsigned AW   = 8,
   parameter int unsigned DW   = 8,
   parameter int unsigned NBLK = 4,
   parameter int unsigned GRP  = 2,
   localparam int unsigned NLINE = NBLK / GRP
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         bus_space,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [AW-1:0]      bus_addr,
   input logic [DW-1:0]      bus_rdata,
   input logic [NBLK*DW-1:0] sts_set,
   input logic [NBLK*DW-1:0] sts_flat,
   input logic [NBLK*DW-1:0] msk_flat,
   input logic [DW-1:0]      vec_q,
   input logic [NLINE-1:0]   irq_line
);

   localparam logic [7:0] TIED = 8'h88;

   logic [NBLK*DW-1:0] tie_all, set_live;
   logic [NLINE-1:0]   pair_hot;
   logic               vec_wr, mask_wr;

   always_comb begin
      for (int b = 0; b < NBLK; b++) begin
         tie_all[b*DW +: DW]  = TIED;
         set_live[b*DW +: DW] = sts_set[b*DW +: DW] & ~TIED;
      end
      for (int k = 0; k < NLINE; k++) begin
         pair_hot[k] = 1'b0;
         for (int j = 0; j < GRP; j++) begin
            pair_hot[k] = pair_hot[k] |
               (|(sts_flat[(k*GRP+j)*DW +: DW] & msk_flat[(k*GRP+j)*DW +: DW]));
         end
      end
   end

   assign vec_wr  = bus_wr && (bus_space == 2'd1 || bus_space == 2'd3) &&
                    (bus_addr == AW'(1));
   assign mask_wr = bus_wr && (bus_space == 2'd0);

   AST_TIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_flat & tie_all) == '0);                                       // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_live != '0) |=> ((sts_flat & $past(set_live)) == $past(set_live))); // R2

   AST_LINE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_line == $past(pair_hot)));                           // R5

   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_wr |=> $stable(vec_q));                                       // R8

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(msk_flat));                                   // R4

   AST_ACK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_space == 2'd2 && bus_addr == '0) |-> (bus_rdata == vec_q)); // R9

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));                                    // R9

endmodule

bind intr_pair_agg intr_pair_agg_chk #(
   .AW   (AW),
   .DW   (DW),
   .NBLK (NBLK),
   .GRP  (BLK_PER_LINE)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_space (bus_space),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .sts_set   (sts_set),
   .sts_flat  (sts_flat),
   .msk_flat  (msk_flat),
   .vec_q     (vec_q),
   .irq_line  (irq_line)
);

// File: tb/test_intr_pair_agg.sv
module test_intr_pair_agg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_space = 2'd0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [2:0]  dec_blk;
   logic [3:0]  dec_chan;
   logic [4:0]  dec_reg;
   logic [31:0] sts_set = '0;
   logic [31:0] sts_clr = '0;
   logic [1:0]  irq_line;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   intr_pair_agg i_intr_pair_agg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_space (bus_space),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .dec_blk   (dec_blk),
      .dec_chan  (dec_chan),
      .dec_reg   (dec_reg),
      .sts_set   (sts_set),
      .sts_clr   (sts_clr),
      .irq_line  (irq_line)
   );

   // behavioural reference model
   logic [7:0] m_sts [4];
   logic [7:0] m_msk [4];
   logic [7:0] m_vec;
   logic [1:0] m_line;

   always @(posedge clk) begin
      logic [7:0] s, c;
      logic [4:0] o;
      int bi;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_sts[i] <= 8'h00;
            m_msk[i] <= 8'h00;
         end
         m_vec  <= 8'h00;
         m_line <= 2'b00;
      end else begin
         m_line[0] <= ((m_sts[0] & m_msk[0]) != 0) || ((m_sts[1] & m_msk[1]) != 0);
         m_line[1] <= ((m_sts[2] & m_msk[2]) != 0) || ((m_sts[3] & m_msk[3]) != 0);
         bi = int'(bus_addr) / 32;
         o  = bus_addr[4:0] ^ 5'h01;
         for (int b = 0; b < 4; b++) begin
            s = m_sts[b];
            c = sts_clr[b*8 +: 8];
            if (bus_wr && bus_space == 2'd0 && bi == b &&
                (o == 5'h05 || o == 5'h15) && bus_wdata[7:4] == 4'h5)
               c = c | 8'h44;
            s = ((s & ~c) | sts_set[b*8 +: 8]) & 8'h77;
            m_sts[b] <= s;
            if (bus_wr && bus_space == 2'd0 && bi == b && o == 5'h0B)
               m_msk[b] <= bus_wdata;
         end
         if (bus_wr && (bus_space == 2'd1 || bus_space == 2'd3) && bus_addr == 8'h01)
            m_vec <= bus_wdata;
      end
   end

   function automatic logic [7:0] model_read(logic [1:0] sp, logic [7:0] a);
      int bi;
      bi = int'(a) / 32;
      if (sp == 2'd0 && bi < 4 && (a[4:0] ^ 5'h01) == 5'h0B) return m_sts[bi];
      if (sp == 2'd2 && (a == 8'h00 || a == 8'h02)) return m_vec;
      return 8'h00;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every cycle: lines against the model
   always @(negedge clk) begin
      if (rst_n && !done) check("R5 line", 32'(irq_line), 32'(m_line));
   end

   task automatic wr(logic [1:0] sp, logic [7:0] a, logic [7:0] d);
      bus_space = sp; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // read with an explicit expected value, cross-checked against the model
   task automatic rd(string req, logic [1:0] sp, logic [7:0] a, logic [7:0] exp);
      bus_space = sp; bus_addr = a; bus_rd = 1'b1;
      #1;
      check(req, 32'(bus_rdata), 32'(exp));
      check({req, " model"}, 32'(bus_rdata), 32'(model_read(sp, a)));
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic strobe(int b, logic [7:0] s, logic [7:0] c);
      sts_set[b*8 +: 8] = s;
      sts_clr[b*8 +: 8] = c;
      @(negedge clk);
      sts_set = '0;
      sts_clr = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 lines in reset", 32'(irq_line), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1 status blk0", 2'd0, 8'h0A, 8'h00);
      rd("R1 status blk3", 2'd0, 8'h6A, 8'h00);
      rd("R1 vector", 2'd2, 8'h00, 8'h00);

      // R2/R5: status set with mask clear keeps line low
      strobe(0, 8'h02, 8'h00);
      idle(2);
      check("R5 masked off", 32'(irq_line), 0);
      rd("R2 status set", 2'd0, 8'h0A, 8'h02);
      // R4: mask write, status unchanged
      wr(2'd0, 8'h0A, 8'h02);
      rd("R4 status after mask write", 2'd0, 8'h0A, 8'h02);
      check("R5 line0 up", 32'(irq_line), 32'h1);

      // R3: tied bits stay zero
      strobe(2, 8'h88, 8'h00);
      rd("R3 tied bits", 2'd0, 8'h4A, 8'h00);

      // R2: set and clear together, then clear alone
      strobe(3, 8'h10, 8'h10);
      rd("R2 set wins", 2'd0, 8'h6A, 8'h10);
      strobe(3, 8'h00, 8'h10);
      rd("R2 clear", 2'd0, 8'h6A, 8'h00);

      // R5: block 3 drives line 1 only; clear line 0 source
      strobe(0, 8'h00, 8'h02);
      strobe(3, 8'h20, 8'h00);
      wr(2'd0, 8'h6A, 8'h20);
      idle(1);
      check("R5 line1 only", 32'(irq_line), 32'h2);
      wr(2'd0, 8'h6A, 8'h00);
      idle(1);
      check("R5 mask drop", 32'(irq_line), 32'h0);

      // R7: break clear command on block 1
      strobe(1, 8'h45, 8'h00);
      wr(2'd0, 8'h24, 8'h30);                 // other command code
      rd("R7 other cmd", 2'd0, 8'h2A, 8'h45);
      wr(2'd0, 8'h24, 8'h50);                 // channel a command slot
      rd("R7 brk clear even", 2'd0, 8'h2A, 8'h01);
      strobe(1, 8'h40, 8'h00);
      wr(2'd0, 8'h34, 8'h5F);                 // channel b command slot
      rd("R7 brk clear odd", 2'd0, 8'h2A, 8'h01);
      // R7: set strobe concurrent with break clear
      bus_space = 2'd0; bus_addr = 8'h24; bus_wdata = 8'h50; bus_wr = 1'b1;
      sts_set[8 +: 8] = 8'h04;
      @(negedge clk);
      bus_wr = 1'b0; sts_set = '0;
      rd("R7 set beats brk clear", 2'd0, 8'h2A, 8'h05);

      // R8/R9: vector paths
      wr(2'd1, 8'h01, 8'hA5);
      rd("R9 ack line0", 2'd2, 8'h00, 8'hA5);
      rd("R9 ack line1", 2'd2, 8'h02, 8'hA5);
      rd("R9 ack other", 2'd2, 8'h01, 8'h00);
      rd("R9 ack high", 2'd2, 8'h04, 8'h00);
      wr(2'd1, 8'h03, 8'h11);
      rd("R8 id other addr", 2'd2, 8'h00, 8'hA5);
      wr(2'd2, 8'h01, 8'h22);
      rd("R8 ack write", 2'd2, 8'h00, 8'hA5);
      wr(2'd3, 8'h01, 8'h3C);
      rd("R8 mem write", 2'd2, 8'h02, 8'h3C);
      wr(2'd3, 8'h00, 8'h77);
      rd("R8 mem other addr", 2'd2, 8'h00, 8'h3C);
      bus_space = 2'd2; bus_addr = 8'h00; #1;
      check("R9 no read strobe", 32'(bus_rdata), 0);

      // R6: decode and unpopulated blocks
      bus_space = 2'd0; bus_addr = 8'hB6; #1;
      check("R6 block idx", 32'(dec_blk), 5);
      check("R6 chan idx", 32'(dec_chan), 32'hB);
      check("R6 reg ofs", 32'(dec_reg), 32'h17);
      bus_addr = 8'h2B; #1;
      check("R6 reg ofs swap", 32'(dec_reg), 32'h0A);
      @(negedge clk);
      strobe(2, 8'h01, 8'h00);
      wr(2'd0, 8'h8A, 8'hFF);                 // block 4 mask: no storage
      wr(2'd0, 8'hE4, 8'h50);
      rd("R6 high block read", 2'd0, 8'hAA, 8'h00);
      idle(2);
      check("R6 high block no line", 32'(irq_line), 32'h0);
      rd("R6 blk2 untouched", 2'd0, 8'h4A, 8'h01);

      idle(2);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule